// File: doc/BRIEF.md
# Range-Gated SECDED Memory Guard

This block sits between a requester and a memory array that stores 72-bit codewords. Each codeword is 64 data bits plus 8 check bits. On the write side it turns the write data into check bits, which are stored next to the data. On the read side it takes the stored data and check bits, computes a syndrome, fixes any single flipped bit, and flags a codeword with two flipped bits as uncorrectable.

Protection applies only when two conditions hold: the global enable is set, and the access address falls inside one of a few programmable address windows. Any other access passes through untouched. With the enable cleared, raw data can be written with zero check bits. Software uses this to plant bit flips that are caught once protection is switched back on.

A small log counts corrected errors and saturates at all ones. The log also holds the 8-byte-aligned address of the first error seen since it was last cleared. A single strobe clears both the count and the pending capture.

Top module: `ecc_range_guard`

## Requirements
- R1: The check bit j for 64-bit data is the XOR of every data bit i whose column has bit j set. The column of data bit i (for i < 56) is the i-th 8-bit value of weight three, counting in ascending numeric order. The column of data bit i (for i >= 56) is the (i-56)-th 8-bit value of weight five, in ascending order. The column of check bit j is 1<<j. `wr_chk` carries these check bits when the write address is protected and carries zero otherwise.
- R2: An address is protected when `ecc_en` is 1 and, for some window k, `rng_en[k]` is 1 and `rng_lo[k] <= addr <= rng_hi[k]`. The bounds are inclusive byte addresses. `wr_prot` reports this for `wr_addr`.
- R3: On a protected read, the syndrome is the recomputed check bits XOR `rd_chk`. If the syndrome equals the column of data bit i, bit i is inverted in `rsp_data` and `rsp_sbe` is 1. If the syndrome has exactly one bit set, the data is returned unchanged and `rsp_sbe` is 1.
- R4: On a protected read, a nonzero syndrome that matches no column raises `rsp_unc` with `rsp_sbe` at 0. In this case the data is returned uncorrected.
- R5: A read of an unprotected address returns `rd_data` unchanged. It raises no flag and is neither counted nor captured.
- R6: `rsp_valid` is high exactly one cycle after `rd_valid`, and the data and flags of that read appear in the same cycle. The flags are 0 whenever `rsp_valid` is 0.
- R7: `err_cnt` rises by one in the cycle in which a response with `rsp_sbe` appears. It holds at all ones once it gets there.
- R8: `log_clr` zeroes `err_cnt` and `err_pend`. If an erroneous read response lands in the same cycle, that event is applied after the clear, so a single error leaves the count at 1 and the capture made.
- R9: On a response with `rsp_sbe` or `rsp_unc` while `err_pend` is 0, `err_addr` takes the read address with bits 2:0 forced to zero and `err_pend` becomes 1. While `err_pend` is 1, `err_addr` holds its value.
- R10: During reset, all registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Global protection enable |
| rng_en | input | NUM_RNG | Per-window enable |
| rng_lo | input | NUM_RNG x ADDR_W | Inclusive window start addresses |
| rng_hi | input | NUM_RNG x ADDR_W | Inclusive window end addresses |
| log_clr | input | 1 | Write-one-to-clear strobe for count and capture |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 64 | Write data |
| wr_chk | output | 8 | Check bits to store, zero if unprotected |
| wr_prot | output | 1 | Write address is protected |
| rd_valid | input | 1 | Read data present this cycle |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | input | 64 | Stored data as read |
| rd_chk | input | 8 | Stored check bits as read |
| rsp_valid | output | 1 | Response valid |
| rsp_data | output | 64 | Corrected or passed-through data |
| rsp_sbe | output | 1 | Single-bit error corrected |
| rsp_unc | output | 1 | Uncorrectable (fatal) error |
| err_cnt | output | CNT_W | Saturating corrected-error count |
| err_pend | output | 1 | An error address is captured |
| err_addr | output | ADDR_W | 8-byte-aligned address of the captured error |

## Verification
Two activities can fall in the same cycle. One is the clear strobe and the other is a read that carries a bit flip. The bench raises `log_clr` in the very cycle that a corrupted read is presented, once with a single flip and once with a double flip. It expects the count to restart at 1 or 0 and the capture to take the new address rather than vanish. A second overlap is a window boundary met by a corrupted read: the addresses at each inclusive edge and one byte outside it are read with the same flip, so protection is judged by whether correction happens. A behavioural model in the bench predicts every output on every clock.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;
   localparam int DATA_W = 64;
   localparam int CHK_W  = 8;

   // Column of data bit idx: weight-3 byte values ascending, then weight-5.
   function automatic logic [CHK_W-1:0] col_of(input int idx);
      int n;
      logic [CHK_W-1:0] r;
      n = 0;
      r = '0;
      for (int w = 3; w <= 5; w += 2) begin
         for (int v = 0; v < 256; v++) begin
            if ($countones(v[7:0]) == w) begin
               if (n == idx) r = v[7:0];
               n++;
            end
         end
      end
      return r;
   endfunction
endpackage

// File: rtl/ecc_rng_match.sv
module ecc_rng_match #(
   parameter int ADDR_W  = 32,
   parameter int NUM_RNG = 3
) (
   input  logic                           ecc_en,
   input  logic [NUM_RNG-1:0]             rng_en,
   input  logic [NUM_RNG-1:0][ADDR_W-1:0] rng_lo,
   input  logic [NUM_RNG-1:0][ADDR_W-1:0] rng_hi,
   input  logic [ADDR_W-1:0]              addr,
   output logic                           prot
);
   logic [NUM_RNG-1:0] hit;

   for (genvar k = 0; k < NUM_RNG; k++) begin : g_win
      assign hit[k] = rng_en[k] && (addr >= rng_lo[k]) && (addr <= rng_hi[k]);
   end

   assign prot = ecc_en && (|hit);
endmodule

// File: rtl/ecc_chk_gen.sv
module ecc_chk_gen
   import ecc_guard_pkg::*;
(
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  chk
);
   logic [CHK_W-1:0][DATA_W-1:0] mask;

   for (genvar i = 0; i < DATA_W; i++) begin : g_col
      localparam logic [CHK_W-1:0] COL = col_of(i);
      for (genvar j = 0; j < CHK_W; j++) begin : g_row
         assign mask[j][i] = COL[j];
      end
   end

   for (genvar j = 0; j < CHK_W; j++) begin : g_par
      assign chk[j] = ^(data & mask[j]);
   end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              sbe_ev,
   input  logic              any_ev,
   input  logic [ADDR_W-1:0] ev_addr,
   output logic [CNT_W-1:0]  cnt,
   output logic              pend,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_base;
   logic             pend_base;

   assign cnt_base  = clr ? '0 : cnt;
   assign pend_base = clr ? 1'b0 : pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
         addr <= '0;
      end else begin
         if (sbe_ev && cnt_base != CNT_MAX) cnt <= cnt_base + 1'b1;
         else                               cnt <= cnt_base;
         if (any_ev && !pend_base) begin
            pend <= 1'b1;
            addr <= ev_addr;
         end else begin
            pend <= pend_base;
         end
      end
   end

   // R7
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));

   // R7
   no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

   // R8
   clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt <= 1));

   // R9
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clr) |=> (pend && $stable(addr)));
endmodule

// File: rtl/ecc_range_guard.sv
module ecc_range_guard
   import ecc_guard_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int NUM_RNG = 3,
   parameter int CNT_W   = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           ecc_en,
   input  logic [NUM_RNG-1:0]             rng_en,
   input  logic [NUM_RNG-1:0][ADDR_W-1:0] rng_lo,
   input  logic [NUM_RNG-1:0][ADDR_W-1:0] rng_hi,
   input  logic                           log_clr,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [DATA_W-1:0]              wr_data,
   output logic [CHK_W-1:0]               wr_chk,
   output logic                           wr_prot,
   input  logic                           rd_valid,
   input  logic [ADDR_W-1:0]              rd_addr,
   input  logic [DATA_W-1:0]              rd_data,
   input  logic [CHK_W-1:0]               rd_chk,
   output logic                           rsp_valid,
   output logic [DATA_W-1:0]              rsp_data,
   output logic                           rsp_sbe,
   output logic                           rsp_unc,
   output logic [CNT_W-1:0]               err_cnt,
   output logic                           err_pend,
   output logic [ADDR_W-1:0]              err_addr
);
   if (NUM_RNG < 1 || NUM_RNG > 8) begin : g_bad_rng
      $error("ecc_range_guard: NUM_RNG must lie in 1..8");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("ecc_range_guard: CNT_W must be at least 2");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ecc_range_guard: ADDR_W must be at least 4");
   end

   // write side
   logic [CHK_W-1:0] wr_raw;

   ecc_rng_match #(.ADDR_W(ADDR_W), .NUM_RNG(NUM_RNG)) u_wr_match (
      .ecc_en(ecc_en), .rng_en(rng_en), .rng_lo(rng_lo), .rng_hi(rng_hi),
      .addr(wr_addr), .prot(wr_prot));

   ecc_chk_gen u_wr_gen (.data(wr_data), .chk(wr_raw));

   assign wr_chk = wr_prot ? wr_raw : '0;

   // read side
   logic              rd_prot;
   logic [CHK_W-1:0]  rd_calc;
   logic [CHK_W-1:0]  syn;
   logic [DATA_W-1:0] hit;
   logic              known;
   logic              sbe_c;
   logic              unc_c;
   logic [DATA_W-1:0] fixed;

   ecc_rng_match #(.ADDR_W(ADDR_W), .NUM_RNG(NUM_RNG)) u_rd_match (
      .ecc_en(ecc_en), .rng_en(rng_en), .rng_lo(rng_lo), .rng_hi(rng_hi),
      .addr(rd_addr), .prot(rd_prot));

   ecc_chk_gen u_rd_gen (.data(rd_data), .chk(rd_calc));

   assign syn = rd_calc ^ rd_chk;

   for (genvar i = 0; i < DATA_W; i++) begin : g_dec
      localparam logic [CHK_W-1:0] COL = col_of(i);
      assign hit[i] = rd_prot && (syn == COL);
   end

   assign known = (|hit) || $onehot(syn);
   assign sbe_c = rd_valid && rd_prot && (syn != '0) && known;
   assign unc_c = rd_valid && rd_prot && (syn != '0) && !known;
   assign fixed = rd_data ^ hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_sbe   <= 1'b0;
         rsp_unc   <= 1'b0;
      end else begin
         rsp_valid <= rd_valid;
         rsp_sbe   <= sbe_c;
         rsp_unc   <= unc_c;
         if (rd_valid) rsp_data <= fixed;
      end
   end

   ecc_err_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_log (
      .clk(clk), .rst_n(rst_n), .clr(log_clr),
      .sbe_ev(sbe_c), .any_ev(sbe_c | unc_c),
      .ev_addr({rd_addr[ADDR_W-1:3], 3'b000}),
      .cnt(err_cnt), .pend(err_pend), .addr(err_addr));

   // R3
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_sbe && rsp_unc));

   // R6
   flag_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_sbe || rsp_unc) |-> rsp_valid);

   // R5
   passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_prot) |=> (rsp_data == $past(rd_data) && !rsp_sbe && !rsp_unc));

   // R9
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_sbe || rsp_unc) |-> err_pend);
endmodule

// File: tb/tb_ecc_range_guard.sv
module tb_ecc_range_guard;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int NR = 3;
   localparam int CW = 8;
   localparam logic [CW-1:0] CMAX = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ecc_en = 1'b0;
   logic [NR-1:0] rng_en = '0;
   logic [NR-1:0][AW-1:0] rng_lo = '0;
   logic [NR-1:0][AW-1:0] rng_hi = '0;
   logic log_clr = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [63:0] wr_data = '0;
   logic [7:0] wr_chk;
   logic wr_prot;
   logic rd_valid = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [63:0] rd_data = '0;
   logic [7:0] rd_chk = '0;
   logic rsp_valid, rsp_sbe, rsp_unc, err_pend;
   logic [63:0] rsp_data;
   logic [CW-1:0] err_cnt;
   logic [AW-1:0] err_addr;

   ecc_range_guard #(.ADDR_W(AW), .NUM_RNG(NR), .CNT_W(CW)) dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int failures = 0;
   string ph = "R10";
   logic [7:0] tcol [64];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] gen(input logic [63:0] d);
      logic [7:0] c = '0;
      for (int i = 0; i < 64; i++) if (d[i]) c ^= tcol[i];
      return c;
   endfunction

   function automatic bit prot_of(input logic [AW-1:0] a);
      bit p = 0;
      for (int k = 0; k < NR; k++)
         if (rng_en[k] && a >= rng_lo[k] && a <= rng_hi[k]) p = 1;
      return ecc_en && p;
   endfunction

   // behavioural reference model
   logic m_valid, m_sbe, m_unc, m_pend;
   logic [63:0] m_data;
   logic [CW-1:0] m_cnt;
   logic [AW-1:0] m_addr;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_valid = 0; m_sbe = 0; m_unc = 0; m_pend = 0;
         m_data = '0; m_cnt = '0; m_addr = '0;
      end else begin
         logic [7:0] s;
         m_valid = rd_valid; m_sbe = 0; m_unc = 0;
         if (rd_valid) begin
            m_data = rd_data;
            if (prot_of(rd_addr)) begin
               s = gen(rd_data) ^ rd_chk;
               if (s != 0) begin
                  for (int i = 0; i < 64; i++)
                     if (tcol[i] == s) begin m_data[i] = ~m_data[i]; m_sbe = 1; end
                  if ($countones(s) == 1) m_sbe = 1;
                  if (!m_sbe) m_unc = 1;
               end
            end
         end
         if (log_clr) begin m_cnt = '0; m_pend = 0; end
         if (m_sbe && m_cnt != CMAX) m_cnt = m_cnt + 1'b1;
         if ((m_sbe || m_unc) && !m_pend) begin
            m_pend = 1; m_addr = rd_addr & ~32'h7;
         end
      end
   end

   task automatic compare();
      bit wp = prot_of(wr_addr);
      chk(rsp_valid === m_valid, "R6", "rsp_valid", 64'(rsp_valid), 64'(m_valid));
      if (m_valid) begin
         chk(rsp_data === m_data, ph, "rsp_data", rsp_data, m_data);
         chk(rsp_sbe === m_sbe, ph, "rsp_sbe", 64'(rsp_sbe), 64'(m_sbe));
         chk(rsp_unc === m_unc, ph, "rsp_unc", 64'(rsp_unc), 64'(m_unc));
      end else begin
         chk(rsp_sbe === 0 && rsp_unc === 0, "R6", "idle flags",
             64'({rsp_sbe, rsp_unc}), 64'(0));
      end
      chk(err_cnt === m_cnt, "R7", "err_cnt", 64'(err_cnt), 64'(m_cnt));
      chk(err_pend === m_pend, "R9", "err_pend", 64'(err_pend), 64'(m_pend));
      chk(err_addr === m_addr, "R9", "err_addr", 64'(err_addr), 64'(m_addr));
      chk(wr_prot === wp, "R2", "wr_prot", 64'(wr_prot), 64'(wp));
      chk(wr_chk === (wp ? gen(wr_data) : 8'h00), "R1", "wr_chk",
          64'(wr_chk), 64'(wp ? gen(wr_data) : 8'h00));
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [63:0] d, input logic [71:0] flip);
      logic [71:0] cw = {gen(d), d} ^ flip;
      rd_valid = 1; rd_addr = a; rd_data = cw[63:0]; rd_chk = cw[71:64];
      step();
   endtask

   task automatic idle();
      rd_valid = 0; log_clr = 0;
      step();
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
      wr_addr = a; wr_data = d;
      step();
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int n = 0;
      foreach (tcol[i]) tcol[i] = '0;
      for (int v = 1; v < 256; v++) if ($countones(v) == 3 && n < 64) begin tcol[n] = 8'(v); n++; end
      for (int v = 1; v < 256; v++) if ($countones(v) == 5 && n < 64) begin tcol[n] = 8'(v); n++; end

      // R10 reset state
      repeat (2) @(negedge clk);
      chk(rsp_valid === 0 && rsp_sbe === 0 && rsp_unc === 0, "R10", "rsp flags",
          64'({rsp_valid, rsp_sbe, rsp_unc}), 64'(0));
      chk(rsp_data === 0 && err_cnt === 0, "R10", "data/cnt", rsp_data | 64'(err_cnt), 64'(0));
      chk(err_pend === 0 && err_addr === 0, "R10", "capture", 64'(err_addr) | 64'(err_pend), 64'(0));
      rst_n = 1;

      ecc_en = 1;
      rng_lo[0] = 32'h0000_1000; rng_hi[0] = 32'h0000_1FFF;
      rng_lo[1] = 32'h8000_0000; rng_hi[1] = 32'h8000_FFFF;
      rng_lo[2] = 32'h0000_4000; rng_hi[2] = 32'h0000_40FF;
      rng_en = 3'b011;
      idle();

      // R1 write side, several patterns
      ph = "R1";
      wr(32'h1000, 64'h0); wr(32'h1008, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(32'h8000_0010, 64'h0123_4567_89AB_CDEF); wr(32'h8000_0018, 64'h8000_0000_0000_0001);
      wr(32'h0000_0100, 64'hDEAD_BEEF_0000_1111);
      for (int i = 0; i < 8; i++) wr(32'h1100 + 32'(i*8), {$urandom, $urandom});

      // clean reads, R3
      ph = "R3";
      rd(32'h1000, 64'h0123_4567_89AB_CDEF, 72'h0);
      rd(32'h8000_0040, 64'hFFFF_0000_FFFF_0000, 72'h0);
      idle();
      // single data-bit flips at several positions
      rd(32'h1010, 64'hA5A5_A5A5_5A5A_5A5A, 72'h1);
      rd(32'h1018, 64'h1111_2222_3333_4444, 72'h1 << 13);
      rd(32'h1020, 64'h0, 72'h1 << 63);
      rd(32'h1028, 64'h0F0F_0F0F_0F0F_0F0F, 72'h1 << 58);
      // check-bit flip
      rd(32'h1030, 64'h7777_6666_5555_4444, 72'h1 << 66);
      idle();

      // R4 double errors
      ph = "R4";
      rd(32'h8000_0100, 64'h1234_5678_9ABC_DEF0, 72'h6);
      rd(32'h8000_0108, 64'hCAFE_F00D_0000_0001, (72'h1 << 5) | (72'h1 << 70));
      rd(32'h8000_0110, 64'h0, (72'h1 << 64) | (72'h1 << 71));
      idle();

      // R8 clear alone, then clear with a single error in the same cycle
      ph = "R8";
      log_clr = 1; idle();
      log_clr = 1; rd(32'h1ABD, 64'h5555_AAAA_5555_AAAA, 72'h1 << 40);
      log_clr = 0; rd(32'h1200, 64'h1, 72'h1 << 3);
      log_clr = 1; rd(32'h8000_0203, 64'h99, 72'h3);
      log_clr = 0; idle();

      // R2 / R5 window edges with a flip
      ph = "R2";
      log_clr = 1; idle();
      rd(32'h0000_1000, 64'hFACE, 72'h1 << 7);
      rd(32'h0000_1FFF, 64'hFACE, 72'h1 << 7);
      ph = "R5";
      rd(32'h0000_0FFF, 64'hFACE, 72'h1 << 7);
      rd(32'h0000_2000, 64'hFACE, 72'h3);
      rd(32'h0000_4010, 64'hFACE, 72'h1 << 7);
      idle();
      ph = "R2";
      rng_en = 3'b111;
      rd(32'h0000_40FF, 64'hFACE, 72'h1 << 9);
      rd(32'h0000_4100, 64'hFACE, 72'h1 << 9);
      ph = "R5";
      ecc_en = 0;
      wr(32'h1000, 64'h1234);
      rd(32'h0000_1000, 64'hFACE, 72'h1 << 7);
      rd(32'h8000_0000, 64'hFACE, 72'h3);
      ecc_en = 1;
      idle();

      // R7 saturation
      ph = "R7";
      log_clr = 1; idle();
      for (int i = 0; i < 262; i++) rd(32'h8000_1000 + 32'(i), 64'(i) * 64'h9E37_79B9, 72'h1 << (i % 72));
      idle();
      idle();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule